// File: doc/BRIEF.md
# Vectored Daisy-Chain Interrupt Controller

This block gathers sixteen interrupt channels into one active-low request line. Eight channels come from internal event strobes, such as timer and serial events. The other eight come from general-purpose input lines, and each of those lines has its own programmable trigger edge. Every channel has four bits, one each of enable, pending, mask and in-service state. Each set of bits is held as a low/high pair of 8-bit registers on a small synchronous register bus. Software can poll the pending registers or use the vectored acknowledge.

On an acknowledge cycle the block answers only when the daisy-chain input shows that no higher-priority device wants service. It then presents an 8-bit vector that names the winning channel and retires that channel's pending bit. The daisy-chain output passes the grant downstream only while the block has no request of its own.

An optional software end-of-interrupt mode marks the acknowledged channel as in service. That mark holds off channels of equal and lower priority until software clears it.

Top module: `vic_chain_top`

## Requirements
- R1: A synchronous reset clears the enable, pending, mask, in-service, edge-polarity and vector registers, so that every register reads 0 and `irq_n` is high.
- R2: The register addresses are 0 edge polarity, 1/2 enable (channels 0-7 / 8-15), 3/4 pending, 5/6 in-service, 7/8 mask and 9 vector control. Enable, mask, edge and vector registers read back the value written. Any other address reads 0 and ignores writes.
- R3: External line `ext_in[k]` feeds channel k (0-7). Edge bit k = 1 selects a rising edge and 0 selects a falling edge. A qualifying edge, measured against the value sampled at the previous clock, sets pending bit k at that clock edge. The opposite edge has no effect.
- R4: Internal strobe `int_src[k]` feeds channel 8+k. When the strobe is high at a clock edge, it sets that channel's pending bit at that edge.
- R5: A channel whose enable bit is 0 never sets its pending bit. A channel whose mask bit is 0 still sets its pending bit but does not take part in the request.
- R6: Writing the pending or in-service registers clears each bit written as 0 and leaves each bit written as 1 unchanged. When a new event and a clear fall in the same cycle, the event wins.
- R7: `irq_n` is low exactly when some channel is pending, unmasked and not held off by an in-service bit.
- R8: `chain_out_n` is low only when `chain_in_n` is low and the block has no request.
- R9: With `iack` high, `chain_in_n` low and a request present, `vec_valid` is 1. In that case `vec_out` is {vector register bits 7:4, 4-bit number of the highest-priority eligible channel}, where channel 15 is the highest and channel 0 the lowest. In every other case `vec_valid` is 0 and `vec_out` is 0.
- R10: At the clock edge that ends an answered acknowledge, the served channel's pending bit clears. The request stays asserted if other eligible channels remain.
- R11: When vector register bit 3 is 1, an answered acknowledge sets the served channel's in-service bit. A set in-service bit holds off all channels of equal and lower priority until software clears it. With bit 3 at 0, no in-service bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on `reg_addr`) |
| int_src | input | 8 | Internal event strobes for channels 8-15 |
| ext_in | input | 8 | External lines for channels 0-7 |
| iack | input | 1 | Acknowledge cycle, one clock per acknowledge |
| chain_in_n | input | 1 | Daisy-chain enable in, active low |
| chain_out_n | output | 1 | Daisy-chain enable out, active low |
| irq_n | output | 1 | Interrupt request, active low |
| vec_valid | output | 1 | Vector being presented this cycle |
| vec_out | output | 8 | Interrupt vector |

## Verification
The assertions assume that `iack` lasts one clock per acknowledge and is sampled in the same cycle as `chain_in_n`. They also assume that reset is held across at least one rising edge. The in-service check further assumes that no reset arrives in the cycle after an acknowledge. The stimulus follows these assumptions by changing every input just after a falling edge and raising `iack` for exactly one cycle. The stimulus also sets up same-cycle collisions on purpose, such as a clearing write together with a new event, an acknowledge while lower channels remain pending, and a nested higher-priority acknowledge while an in-service bit is set. In these cases the winner is fixed by the requirements.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int DW      = 8;
    localparam int NEXT    = 8;
    localparam int NINT    = 8;
    localparam int NCH     = NEXT + NINT;
    localparam int ID_W    = $clog2(NCH);
    localparam int VB_W    = DW - ID_W;
    localparam int AW      = 4;
    localparam int EOI_BIT = 3;

    typedef enum logic [AW-1:0] {
        RG_EDGE   = 4'd0,
        RG_EN_LO  = 4'd1,
        RG_EN_HI  = 4'd2,
        RG_PND_LO = 4'd3,
        RG_PND_HI = 4'd4,
        RG_ISV_LO = 4'd5,
        RG_ISV_HI = 4'd6,
        RG_MSK_LO = 4'd7,
        RG_MSK_HI = 4'd8,
        RG_VEC    = 4'd9
    } vic_reg_e;

    typedef struct packed {
        logic            hit;
        logic [ID_W-1:0] id;
    } vic_win_t;

    // replace one byte-wide half of a channel vector
    function automatic logic [NCH-1:0] put_half(input logic [NCH-1:0] q,
                                                input logic hi,
                                                input logic [DW-1:0] d);
        logic [NCH-1:0] r;
        r = q;
        if (hi) r[NCH-1:NCH-DW] = d;
        else    r[DW-1:0]       = d;
        return r;
    endfunction

    // bits written as zero become clear requests
    function automatic logic [NCH-1:0] zero_half(input logic hi,
                                                 input logic [DW-1:0] d);
        logic [NCH-1:0] r;
        r = '0;
        if (hi) r[NCH-1:NCH-DW] = ~d;
        else    r[DW-1:0]       = ~d;
        return r;
    endfunction

    function automatic logic [NCH-1:0] id_bit(input logic [ID_W-1:0] id);
        return NCH'(1) << id;
    endfunction

endpackage

// File: rtl/vic_edge_sense.sv
module vic_edge_sense
    import vic_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NEXT-1:0] line,
    input  logic [NEXT-1:0] pol,
    output logic [NEXT-1:0] evt
);
    logic [NEXT-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= line;
    end

    genvar g;
    generate
        for (g = 0; g < NEXT; g++) begin : g_line
            assign evt[g] = pol[g] ? (line[g] & ~prev_q[g])
                                   : (~line[g] & prev_q[g]);
        end
    endgenerate
endmodule

// File: rtl/vic_svc_gate.sv
module vic_svc_gate
    import vic_pkg::*;
(
    input  logic [NCH-1:0] isr,
    output logic [NCH-1:0] allow
);
    // a channel is allowed only when nothing at its level or above is in service
    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            assign allow[g] = ~|isr[NCH-1:g];
        end
    endgenerate
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick
    import vic_pkg::*;
(
    input  logic [NCH-1:0] req,
    output vic_win_t       win
);
    always_comb begin
        win = '0;
        for (int i = 0; i < NCH; i++) begin
            if (req[i]) begin
                win.hit = 1'b1;
                win.id  = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/vic_chain_top.sv
module vic_chain_top
    import vic_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_we,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [NINT-1:0] int_src,
    input  logic [NEXT-1:0] ext_in,
    input  logic          iack,
    input  logic          chain_in_n,
    output logic          chain_out_n,
    output logic          irq_n,
    output logic          vec_valid,
    output logic [DW-1:0] vec_out
);
    logic [NCH-1:0]  enb_q, msk_q, pnd_q, isr_q;
    logic [NCH-1:0]  pnd_d, isr_d, evt, allow, elig, pclr, iclr, iset;
    logic [NEXT-1:0] pol_q, ext_evt;
    logic [DW-1:0]   vec_q;
    vic_win_t        win;
    vic_reg_e        ra;
    logic            ack_ok;

    assign ra = vic_reg_e'(reg_addr);

    vic_edge_sense u_edge (
        .clk  (clk),
        .rst  (rst),
        .line (ext_in),
        .pol  (pol_q),
        .evt  (ext_evt)
    );

    assign evt = {int_src, ext_evt};

    vic_svc_gate u_gate (
        .isr   (isr_q),
        .allow (allow)
    );

    assign elig = pnd_q & msk_q & allow;

    vic_prio_pick u_pick (
        .req (elig),
        .win (win)
    );

    assign ack_ok      = iack & ~chain_in_n & win.hit;
    assign irq_n       = ~win.hit;
    assign chain_out_n = chain_in_n | win.hit;
    assign vec_valid   = ack_ok;
    assign vec_out     = ack_ok ? {vec_q[DW-1:ID_W], win.id} : '0;

    always_comb begin
        pclr = '0;
        iclr = '0;
        iset = '0;
        if (reg_we) begin
            case (ra)
                RG_PND_LO: pclr = zero_half(1'b0, reg_wdata);
                RG_PND_HI: pclr = zero_half(1'b1, reg_wdata);
                RG_ISV_LO: iclr = zero_half(1'b0, reg_wdata);
                RG_ISV_HI: iclr = zero_half(1'b1, reg_wdata);
                default: ;
            endcase
        end
        if (ack_ok) begin
            pclr = pclr | id_bit(win.id);
            if (vec_q[EOI_BIT]) iset = id_bit(win.id);
        end
        pnd_d = (pnd_q & ~pclr) | (evt & enb_q);
        isr_d = (isr_q & ~iclr) | iset;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enb_q <= '0;
            msk_q <= '0;
            pnd_q <= '0;
            isr_q <= '0;
            pol_q <= '0;
            vec_q <= '0;
        end else begin
            pnd_q <= pnd_d;
            isr_q <= isr_d;
            if (reg_we) begin
                case (ra)
                    RG_EDGE:   pol_q <= reg_wdata;
                    RG_EN_LO:  enb_q <= put_half(enb_q, 1'b0, reg_wdata);
                    RG_EN_HI:  enb_q <= put_half(enb_q, 1'b1, reg_wdata);
                    RG_MSK_LO: msk_q <= put_half(msk_q, 1'b0, reg_wdata);
                    RG_MSK_HI: msk_q <= put_half(msk_q, 1'b1, reg_wdata);
                    RG_VEC:    vec_q <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (ra)
            RG_EDGE:   reg_rdata = pol_q;
            RG_EN_LO:  reg_rdata = enb_q[DW-1:0];
            RG_EN_HI:  reg_rdata = enb_q[NCH-1:NCH-DW];
            RG_PND_LO: reg_rdata = pnd_q[DW-1:0];
            RG_PND_HI: reg_rdata = pnd_q[NCH-1:NCH-DW];
            RG_ISV_LO: reg_rdata = isr_q[DW-1:0];
            RG_ISV_HI: reg_rdata = isr_q[NCH-1:NCH-DW];
            RG_MSK_LO: reg_rdata = msk_q[DW-1:0];
            RG_MSK_HI: reg_rdata = msk_q[NCH-1:NCH-DW];
            RG_VEC:    reg_rdata = vec_q;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/vic_chain_chk.sv
module vic_chain_chk
    import vic_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           iack,
    input logic           chain_in_n,
    input logic           chain_out_n,
    input logic           irq_n,
    input logic           vec_valid,
    input logic [DW-1:0]  vec_out,
    input logic [NCH-1:0] pnd,
    input logic [NCH-1:0] enb,
    input logic [NCH-1:0] msk,
    input logic [NCH-1:0] isr,
    input logic           eoi
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pnd == '0 && enb == '0 && msk == '0 && isr == '0));

    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (pnd & ~$past(pnd) & ~$past(enb)) == '0);

    assert_ieo_block_R8: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> chain_out_n);

    assert_ieo_upstream_R8: assert property (@(posedge clk) disable iff (rst)
        chain_in_n |-> chain_out_n);

    assert_ack_gate_R9: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (iack && !chain_in_n && !irq_n));

    assert_idle_vector_R9: assert property (@(posedge clk) disable iff (rst)
        !vec_valid |-> (vec_out == '0));

    assert_eoi_mark_R11: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && eoi) |=> ((isr >> $past(vec_out[ID_W-1:0])) & NCH'(1)) != '0);
endmodule

bind vic_chain_top vic_chain_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .iack        (iack),
    .chain_in_n  (chain_in_n),
    .chain_out_n (chain_out_n),
    .irq_n       (irq_n),
    .vec_valid   (vec_valid),
    .vec_out     (vec_out),
    .pnd         (pnd_q),
    .enb         (enb_q),
    .msk         (msk_q),
    .isr         (isr_q),
    .eoi         (vec_q[3])
);

// File: tb/sim_vic_chain_top.sv
module sim_vic_chain_top;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] int_src = '0;
    logic [7:0] ext_in = '0;
    logic       iack = 1'b0;
    logic       chain_in_n = 1'b0;
    logic       chain_out_n, irq_n, vec_valid;
    logic [7:0] vec_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    vic_chain_top u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .int_src(int_src),
        .ext_in(ext_in), .iack(iack), .chain_in_n(chain_in_n),
        .chain_out_n(chain_out_n), .irq_n(irq_n), .vec_valid(vec_valid),
        .vec_out(vec_out)
    );

    // {address, write data, expected read}
    localparam logic [19:0] TBL [0:7] = '{
        {4'd1,  8'hA5, 8'hA5},
        {4'd2,  8'h3C, 8'h3C},
        {4'd7,  8'h5A, 8'h5A},
        {4'd8,  8'hC3, 8'hC3},
        {4'd0,  8'h0F, 8'h0F},
        {4'd9,  8'h4B, 8'h4B},
        {4'd3,  8'hFF, 8'h00},
        {4'd10, 8'h77, 8'h00}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic pulse_int(input logic [7:0] v);
        int_src = v;
        @(negedge clk);
        int_src = '0;
    endtask

    task automatic set_ext(input logic [7:0] v);
        ext_in = v;
        @(negedge clk);
    endtask

    task automatic ack(input logic ev, input logic [7:0] evec, input string tag);
        iack = 1'b1;
        #1;
        check(tag, {7'd0, vec_valid}, {7'd0, ev});
        check(tag, vec_out, evec);
        @(negedge clk);
        iack = 1'b0;
    endtask

    task automatic reset_dut();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        reset_dut();

        // R1: state after reset
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);
        check("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
        for (int a = 0; a < 10; a++) rd(4'(a), 8'h00, "R1 register zero");

        // R2: table walk of writes and readbacks
        for (int i = 0; i < 8; i++) begin
            wr(TBL[i][19:16], TBL[i][15:8]);
            rd(TBL[i][19:16], TBL[i][7:0], "R2 readback");
        end

        // R1: reset mid-run clears everything written above
        reset_dut();
        for (int a = 0; a < 10; a++) rd(4'(a), 8'h00, "R1 reset after writes");

        // R3: edges on external lines; ch0 rising, ch1 falling, all masked
        wr(4'd0, 8'h01);
        wr(4'd1, 8'hFF);
        set_ext(8'h01);
        rd(4'd3, 8'h01, "R3 rising edge ch0");
        check("R5 masked no request", {7'd0, irq_n}, 8'h01);
        set_ext(8'h03);
        rd(4'd3, 8'h01, "R3 rise ignored on falling line");
        set_ext(8'h01);
        rd(4'd3, 8'h03, "R3 falling edge ch1");
        wr(4'd3, 8'h00);
        rd(4'd3, 8'h00, "R6 pending cleared by zero write");
        set_ext(8'h00);
        rd(4'd3, 8'h00, "R3 fall ignored on rising line");

        // R5: disabled channels never go pending
        wr(4'd1, 8'h00);
        set_ext(8'h01);
        rd(4'd3, 8'h00, "R5 disabled external");
        pulse_int(8'h04);
        rd(4'd4, 8'h00, "R5 disabled internal");

        // R4: internal strobe
        wr(4'd2, 8'hFF);
        pulse_int(8'h04);
        rd(4'd4, 8'h04, "R4 internal ch10 pending");
        check("R5 masked ch10 quiet", {7'd0, irq_n}, 8'h01);

        // R7 / R8: unmask raises the request and blocks the chain
        wr(4'd8, 8'h04);
        check("R7 irq asserted", {7'd0, irq_n}, 8'h00);
        check("R8 chain out blocked", {7'd0, chain_out_n}, 8'h01);
        chain_in_n = 1'b1;
        ack(1'b0, 8'h00, "R9 no answer without chain grant");
        rd(4'd4, 8'h04, "R9 pending kept when not granted");
        chain_in_n = 1'b0;

        // R9 / R10: vectored acknowledge, priority order
        wr(4'd0, 8'hFF);
        wr(4'd1, 8'hFF);
        wr(4'd7, 8'hFF);
        wr(4'd9, 8'h50);
        set_ext(8'h21);
        rd(4'd3, 8'h20, "R3 rising edge ch5");
        ack(1'b1, 8'h5A, "R9 vector ch10");
        rd(4'd4, 8'h00, "R10 served pending cleared");
        check("R10 request stays", {7'd0, irq_n}, 8'h00);
        ack(1'b1, 8'h55, "R9 vector ch5");
        check("R10 request drops", {7'd0, irq_n}, 8'h01);
        check("R8 chain passes", {7'd0, chain_out_n}, 8'h00);
        ack(1'b0, 8'h00, "R9 no request no answer");
        rd(4'd6, 8'h00, "R11 no in-service without eoi mode");

        // R6: event wins over a clearing write in the same cycle
        reg_addr = 4'd4; reg_wdata = 8'h00; reg_we = 1'b1; int_src = 8'h01;
        @(negedge clk);
        reg_we = 1'b0; int_src = '0;
        rd(4'd4, 8'h01, "R6 set wins over clear");
        wr(4'd4, 8'hFF);
        rd(4'd4, 8'h01, "R6 ones leave pending");
        wr(4'd4, 8'h00);
        rd(4'd4, 8'h00, "R6 zeros clear pending");

        // R11: software end-of-interrupt nesting
        wr(4'd8, 8'hFF);
        wr(4'd9, 8'h58);
        pulse_int(8'h06);
        rd(4'd4, 8'h06, "R4 two internal pending");
        ack(1'b1, 8'h5A, "R11 vector ch10");
        rd(4'd6, 8'h04, "R11 in-service ch10 set");
        check("R11 lower channel held off", {7'd0, irq_n}, 8'h01);
        pulse_int(8'h10);
        check("R11 higher channel requests", {7'd0, irq_n}, 8'h00);
        ack(1'b1, 8'h5C, "R11 nested vector ch12");
        rd(4'd6, 8'h14, "R11 nested in-service");
        wr(4'd6, 8'h04);
        rd(4'd6, 8'h04, "R6 in-service zero write clears");
        check("R11 still held by ch10", {7'd0, irq_n}, 8'h01);
        wr(4'd6, 8'h00);
        check("R11 released request", {7'd0, irq_n}, 8'h00);
        ack(1'b1, 8'h59, "R11 vector ch9 after release");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule